// File: doc/BRIEF.md
# Saturating Fixed-Point PID Duty Compensator

This block closes a converter voltage loop in hardware. Each time a fresh sample of the converter output arrives, marked by a single-cycle valid strobe, the block subtracts the unsigned sample code from a programmable unsigned target code. The resulting signed error drives a proportional, an integral and a derivative path. Each path has its own signed fixed-point gain. The three terms are summed, rounded to an integer and clamped, and the result is sent to a digital pulse-width modulator as a new duty command.

All arithmetic saturates rather than wrapping. The proportional product is bounded by its own limit. The running error sum is held inside a symmetric window, which also stops integral wind-up. The final duty value is clamped to 0 through 255. The block is fully pipelined: a new sample may arrive on every clock, and each sample yields exactly one result a fixed three cycles later.

Top module: `pid_duty_comp`

## Requirements
- R1: The error for a sample is the target code minus the sample code. Both codes are unsigned ADC_W-bit values, and the error is a signed two's-complement value, so a sample above the target gives a negative error.
- R2: The result is round((Kp*e + Ki*S + Kd*(e - e_prev)) / 256). Here S is the saturated sum of all errors since reset, including the current one, and e_prev is the error of the preceding sample. Kp, Ki and Kd are 16-bit two's-complement Q8.8 gains (256 means 1.0), sampled together with the sample code.
- R3: Before the sum, the product Kp*e is limited to the range -P_LIM to +P_LIM (default 65535). The integral and derivative products are not limited.
- R4: The error sum S never leaves -ACC_LIM to +ACC_LIM (default 2048). An error that would push S past a bound leaves S at that bound. An error of the opposite sign moves S away from the bound at once (anti-windup).
- R5: Rounding adds 128 to the Q8.8 sum and then shifts arithmetically right by 8, so an exact half rounds upward.
- R6: The rounded value is clamped to 0 through 255 before it is output on `duty`.
- R7: `duty` and a one-cycle `duty_done` pulse update on the third rising edge, counting the edge that captures `sample_vld`. `duty` holds its value at all other times.
- R8: A synchronous reset clears the error sum, the stored previous error, `duty` (to 0) and `duty_done` (to 0).
- R9: Samples on consecutive clocks each produce their own result, on consecutive clocks and in order.
- R10: The first sample after reset treats the previous error as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample_vld | input | 1 | One-cycle strobe marking a new sample |
| adc_code | input | ADC_W | Unsigned converter output sample |
| ref_code | input | ADC_W | Unsigned target code |
| kp | input | GAIN_W | Signed Q8.8 proportional gain |
| ki | input | GAIN_W | Signed Q8.8 integral gain |
| kd | input | GAIN_W | Signed Q8.8 derivative gain |
| duty | output | DUTY_W | Rounded and clamped duty command |
| duty_done | output | 1 | One-cycle pulse when `duty` carries a new result |

## Verification
The bench drives the error sum hard into each bound and then reverses the sign of the error. A design that keeps integrating past the bound, or that wraps, returns a visibly different duty after the reversal. A proportional product far above its limit is paired with a negative integral term, so a missing limiter shows up as a clamp to 255 where a mid-range value is expected. Exact half results check round-half-up, and deep negative sums and huge positive sums check both clamps. A reset after heavy activity, followed by a sample using both integral and derivative gains, catches a stale error sum or previous error. Back-to-back strobes expose any stage that shares registers between neighbouring samples.

// File: rtl/pid_duty_pkg.sv
`timescale 1ns/1ps
package pid_duty_pkg;
   // fractional bits of the gain format (Q8.8)
   localparam int unsigned DEF_GAIN_FRAC = 8;
   // width of the duty command handed to the modulator
   localparam int unsigned DEF_DUTY_W    = 8;
endpackage

// File: rtl/pid_err_stage.sv
`timescale 1ns/1ps
// Stage 1: error, error difference, saturating error sum, gain capture.
module pid_err_stage #(
   parameter int ADC_W   = 10,
   parameter int GAIN_W  = 16,
   parameter int ACC_LIM = 2048,
   parameter int ACC_W   = 13
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_i,
   input  logic [ADC_W-1:0]         adc_i,
   input  logic [ADC_W-1:0]         ref_i,
   input  logic signed [GAIN_W-1:0] kp_i,
   input  logic signed [GAIN_W-1:0] ki_i,
   input  logic signed [GAIN_W-1:0] kd_i,
   output logic                     vld_o,
   output logic signed [ADC_W:0]    err_o,
   output logic signed [ADC_W+1:0]  dlt_o,
   output logic signed [ACC_W-1:0]  acc_o,
   output logic signed [GAIN_W-1:0] kp_o,
   output logic signed [GAIN_W-1:0] ki_o,
   output logic signed [GAIN_W-1:0] kd_o
);
   localparam int E_W = ADC_W + 1;
   localparam logic signed [ACC_W:0] ACC_HI = (ACC_W+1)'(ACC_LIM);
   localparam logic signed [ACC_W:0] ACC_LO = -ACC_HI;

   if (ACC_W <= E_W) begin : g_bad_acc
      $error("pid_err_stage: accumulator narrower than error plus one bit");
   end
   if (ACC_LIM <= 0) begin : g_bad_lim
      $error("pid_err_stage: ACC_LIM must be positive");
   end

   logic signed [E_W-1:0]   err_now;
   logic signed [E_W-1:0]   prev_q;
   logic signed [E_W:0]     dlt_now;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W:0]   acc_sum;
   logic signed [ACC_W:0]   acc_sat;

   always_comb begin
      err_now = $signed({1'b0, ref_i}) - $signed({1'b0, adc_i});
      dlt_now = (E_W+1)'(err_now) - (E_W+1)'(prev_q);
      acc_sum = (ACC_W+1)'(acc_q) + (ACC_W+1)'(err_now);
      if (acc_sum > ACC_HI)      acc_sat = ACC_HI;
      else if (acc_sum < ACC_LO) acc_sat = ACC_LO;
      else                       acc_sat = acc_sum;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o  <= 1'b0;
         err_o  <= '0;
         dlt_o  <= '0;
         prev_q <= '0;
         acc_q  <= '0;
         kp_o   <= '0;
         ki_o   <= '0;
         kd_o   <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            err_o  <= err_now;
            dlt_o  <= dlt_now;
            prev_q <= err_now;
            acc_q  <= acc_sat[ACC_W-1:0];
            kp_o   <= kp_i;
            ki_o   <= ki_i;
            kd_o   <= kd_i;
         end
      end
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/pid_gain_term.sv
`timescale 1ns/1ps
// Stage 2 lane: full-width signed product, optional symmetric limiter.
module pid_gain_term #(
   parameter int GAIN_W = 16,
   parameter int OP_W   = 11,
   parameter int OUT_W  = 29,
   parameter int LIMIT  = 0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [GAIN_W-1:0] gain_i,
   input  logic signed [OP_W-1:0]   op_i,
   output logic signed [OUT_W-1:0]  term_o
);
   localparam int P_W = GAIN_W + OP_W;

   if (OUT_W < P_W) begin : g_bad_out
      $error("pid_gain_term: output narrower than product");
   end
   if (LIMIT < 0) begin : g_bad_limit
      $error("pid_gain_term: LIMIT must not be negative");
   end

   logic signed [P_W-1:0] prod;
   logic signed [P_W-1:0] lim_v;

   assign prod = P_W'(gain_i) * P_W'(op_i);

   if (LIMIT > 0) begin : g_lim
      localparam logic signed [P_W-1:0] HI = P_W'(LIMIT);
      localparam logic signed [P_W-1:0] LO = -HI;
      always_comb begin
         if (prod > HI)      lim_v = HI;
         else if (prod < LO) lim_v = LO;
         else                lim_v = prod;
      end
   end else begin : g_pass
      assign lim_v = prod;
   end

   always_ff @(posedge clk) begin
      if (rst) term_o <= '0;
      else     term_o <= OUT_W'(lim_v);
   end
endmodule

// File: rtl/pid_out_stage.sv
`timescale 1ns/1ps
// Stage 3: sum, round half up, clamp to duty range, done pulse.
module pid_out_stage #(
   parameter int IN_W   = 29,
   parameter int DUTY_W = 8,
   parameter int FRAC   = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    vld_i,
   input  logic signed [IN_W-1:0]  p_i,
   input  logic signed [IN_W-1:0]  i_i,
   input  logic signed [IN_W-1:0]  d_i,
   output logic [DUTY_W-1:0]       duty_o,
   output logic                    done_o
);
   localparam int S_W = IN_W + 2;
   localparam logic signed [S_W-1:0] HALF = S_W'(longint'(1) << (FRAC-1));
   localparam logic signed [S_W-1:0] DMAX = S_W'((longint'(1) << DUTY_W) - 1);

   if (FRAC < 1) begin : g_bad_frac
      $error("pid_out_stage: FRAC must be at least 1");
   end
   if (DUTY_W >= S_W - 1) begin : g_bad_duty
      $error("pid_out_stage: duty wider than sum");
   end

   logic signed [S_W-1:0] sum;
   logic signed [S_W-1:0] shf;
   logic [DUTY_W-1:0]     dsat;

   always_comb begin
      sum = S_W'(p_i) + S_W'(i_i) + S_W'(d_i) + HALF;
      shf = sum >>> FRAC;
      if (shf[S_W-1])     dsat = '0;
      else if (shf > DMAX) dsat = DMAX[DUTY_W-1:0];
      else                dsat = shf[DUTY_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         duty_o <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= vld_i;
         if (vld_i) duty_o <= dsat;
      end
   end
endmodule

// File: rtl/pid_duty_comp.sv
`timescale 1ns/1ps
module pid_duty_comp
   import pid_duty_pkg::*;
#(
   parameter int ADC_W     = 10,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = DEF_GAIN_FRAC,
   parameter int ACC_LIM   = 2048,
   parameter int P_LIM     = 65535,
   parameter int DUTY_W    = DEF_DUTY_W
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     sample_vld,
   input  logic [ADC_W-1:0]         adc_code,
   input  logic [ADC_W-1:0]         ref_code,
   input  logic signed [GAIN_W-1:0] kp,
   input  logic signed [GAIN_W-1:0] ki,
   input  logic signed [GAIN_W-1:0] kd,
   output logic [DUTY_W-1:0]        duty,
   output logic                     duty_done
);
   localparam int E_W    = ADC_W + 1;
   localparam int ACC_W  = $clog2(ACC_LIM + 1) + 1;
   localparam int TERM_W = GAIN_W + ACC_W;

   if (GAIN_FRAC >= GAIN_W) begin : g_bad_gain
      $error("pid_duty_comp: gain fraction exceeds gain width");
   end

   logic                     vld1, vld2;
   logic signed [E_W-1:0]    err1;
   logic signed [E_W:0]      dlt1;
   logic signed [ACC_W-1:0]  acc1;
   logic signed [GAIN_W-1:0] kp1, ki1, kd1;
   logic signed [TERM_W-1:0] p2, i2, d2;

   pid_err_stage #(
      .ADC_W(ADC_W), .GAIN_W(GAIN_W), .ACC_LIM(ACC_LIM), .ACC_W(ACC_W)
   ) u_err (
      .clk(clk), .rst(rst), .vld_i(sample_vld), .adc_i(adc_code),
      .ref_i(ref_code), .kp_i(kp), .ki_i(ki), .kd_i(kd),
      .vld_o(vld1), .err_o(err1), .dlt_o(dlt1), .acc_o(acc1),
      .kp_o(kp1), .ki_o(ki1), .kd_o(kd1)
   );

   pid_gain_term #(
      .GAIN_W(GAIN_W), .OP_W(E_W), .OUT_W(TERM_W), .LIMIT(P_LIM)
   ) u_prop (
      .clk(clk), .rst(rst), .gain_i(kp1), .op_i(err1), .term_o(p2)
   );

   pid_gain_term #(
      .GAIN_W(GAIN_W), .OP_W(ACC_W), .OUT_W(TERM_W), .LIMIT(0)
   ) u_intg (
      .clk(clk), .rst(rst), .gain_i(ki1), .op_i(acc1), .term_o(i2)
   );

   pid_gain_term #(
      .GAIN_W(GAIN_W), .OP_W(E_W + 1), .OUT_W(TERM_W), .LIMIT(0)
   ) u_derv (
      .clk(clk), .rst(rst), .gain_i(kd1), .op_i(dlt1), .term_o(d2)
   );

   always_ff @(posedge clk) begin
      if (rst) vld2 <= 1'b0;
      else     vld2 <= vld1;
   end

   pid_out_stage #(
      .IN_W(TERM_W), .DUTY_W(DUTY_W), .FRAC(GAIN_FRAC)
   ) u_out (
      .clk(clk), .rst(rst), .vld_i(vld2), .p_i(p2), .i_i(i2), .d_i(d2),
      .duty_o(duty), .done_o(duty_done)
   );
endmodule

// File: rtl/pid_duty_comp_chk.sv
`timescale 1ns/1ps
module pid_duty_comp_chk #(
   parameter int ACC_W   = 13,
   parameter int ACC_LIM = 2048,
   parameter int DUTY_W  = 8
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    sample_vld,
   input logic [DUTY_W-1:0]       duty,
   input logic                    duty_done,
   input logic signed [ACC_W-1:0] acc
);
   localparam logic signed [ACC_W-1:0] HI = ACC_W'(ACC_LIM);
   localparam logic signed [ACC_W-1:0] LO = -HI;

   logic [2:0] vpipe;
   always_ff @(posedge clk) begin
      if (rst) vpipe <= '0;
      else     vpipe <= {vpipe[1:0], sample_vld};
   end

   // R7
   done_latency_chk: assert property (@(posedge clk) disable iff (rst)
      duty_done == vpipe[2]);

   // R7
   duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(duty) |-> duty_done);

   // R4
   acc_window_chk: assert property (@(posedge clk) disable iff (rst)
      (acc <= HI) && (acc >= LO));

   // R8
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (duty == '0 && !duty_done && acc == '0));
endmodule

bind pid_duty_comp pid_duty_comp_chk #(
   .ACC_W(ACC_W), .ACC_LIM(ACC_LIM), .DUTY_W(DUTY_W)
) u_chk (
   .clk(clk), .rst(rst), .sample_vld(sample_vld), .duty(duty),
   .duty_done(duty_done), .acc(u_err.acc_o)
);

// File: tb/pid_duty_comp_bench.sv
`timescale 1ns/1ps
module pid_duty_comp_bench;
   logic              clk = 1'b0;
   logic              rst;
   logic              vld;
   logic [9:0]        refc, adc;
   logic signed [15:0] kp, ki, kd;
   logic [7:0]        duty;
   logic              done;
   int                checks = 0;
   int                errors = 0;

   always #2 clk = ~clk;

   pid_duty_comp u_pid_duty_comp (
      .clk(clk), .rst(rst), .sample_vld(vld), .adc_code(adc),
      .ref_code(refc), .kp(kp), .ki(ki), .kd(kd),
      .duty(duty), .duty_done(done)
   );

   typedef struct packed {
      logic [9:0]  r;
      logic [9:0]  a;
      logic [15:0] p;
      logic [15:0] i;
      logic [15:0] d;
      logic [7:0]  e;
   } vec_t;

   // vectors run in order from reset; error sum and previous error carry over
   localparam vec_t VEC [8] = '{
      '{10'd512, 10'd500, 16'h0200, 16'h0000, 16'h0000, 8'd24},
      '{10'd512, 10'd502, 16'h0180, 16'h0010, 16'h0000, 8'd16},
      '{10'd512, 10'd520, 16'h0100, 16'h0010, 16'h0080, 8'd0},
      '{10'd512, 10'd507, 16'h0080, 16'h0000, 16'h0000, 8'd3},
      '{10'd600, 10'd500, 16'h7FFF, 16'hFF00, 16'h0000, 8'd137},
      '{10'd600, 10'd450, 16'h0000, 16'h0000, 16'h0100, 8'd50},
      '{10'd512, 10'd512, 16'h0000, 16'h0040, 16'h0000, 8'd67},
      '{10'd1023, 10'd0,  16'h0000, 16'h0000, 16'h0100, 8'd255}
   };

   task automatic chk(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [9:0] r, a, input logic [15:0] p, i, d);
      refc = r; adc = a; kp = p; ki = i; kd = d; vld = 1'b1;
   endtask

   task automatic run(input logic [9:0] r, a, input logic [15:0] p, i, d,
                      input int exp, input string tag);
      drive(r, a, p, i, d);
      @(negedge clk); vld = 1'b0;
      repeat (2) @(negedge clk);
      chk(int'(duty), exp, tag);
      chk(int'(done), 1, "R7 done with result");
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(int'(duty), 0, "R8 duty cleared");
      chk(int'(done), 0, "R8 done cleared");
      rst = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; vld = 1'b0; refc = '0; adc = '0; kp = '0; ki = '0; kd = '0;
      repeat (3) @(negedge clk);
      chk(int'(duty), 0, "R8 reset duty");
      chk(int'(done), 0, "R8 reset done");
      rst = 1'b0;
      @(negedge clk);

      // R1 R2 R3 R5 R6: table of vectors
      for (int n = 0; n < 8; n++) begin
         run(VEC[n].r, VEC[n].a, VEC[n].p, VEC[n].i, VEC[n].d, int'(VEC[n].e),
             $sformatf("R1 R2 R3 R5 R6 vector %0d", n));
      end

      // R7: exact latency and hold
      drive(10'd600, 10'd590, 16'h0100, 16'h0000, 16'h0000);
      @(negedge clk); vld = 1'b0;
      chk(int'(done), 0, "R7 no done after edge 1");
      @(negedge clk);
      chk(int'(done), 0, "R7 no done after edge 2");
      @(negedge clk);
      chk(int'(done), 1, "R7 done after edge 3");
      chk(int'(duty), 10, "R7 duty after edge 3");
      @(negedge clk);
      chk(int'(done), 0, "R7 done lasts one cycle");
      chk(int'(duty), 10, "R7 duty held");

      // R9: back-to-back samples
      drive(10'd600, 10'd597, 16'h0100, 16'h0000, 16'h0000);
      @(negedge clk);
      drive(10'd600, 10'd593, 16'h0100, 16'h0000, 16'h0000);
      @(negedge clk); vld = 1'b0;
      @(negedge clk);
      chk(int'(duty), 3, "R9 first result");
      chk(int'(done), 1, "R9 first done");
      @(negedge clk);
      chk(int'(duty), 7, "R9 second result");
      chk(int'(done), 1, "R9 second done");
      @(negedge clk);
      chk(int'(done), 0, "R9 done ends");

      // R4: positive bound with anti-windup
      do_reset();
      run(10'd1023, 10'd0, 16'h0000, 16'h0010, 16'h0000, 64, "R4 sum 1023");
      run(10'd1023, 10'd0, 16'h0000, 16'h0010, 16'h0000, 128, "R4 sum 2046");
      run(10'd1023, 10'd0, 16'h0000, 16'h0010, 16'h0000, 128, "R4 sum at +bound");
      run(10'd1023, 10'd0, 16'h0000, 16'h0010, 16'h0000, 128, "R4 sum held at +bound");
      run(10'd0, 10'd1000, 16'h0000, 16'h0010, 16'h0000, 66, "R4 unwind from +bound");

      // R4: negative bound with anti-windup
      do_reset();
      run(10'd0, 10'd1023, 16'h0000, 16'hFFF0, 16'h0000, 64, "R4 sum -1023");
      run(10'd0, 10'd1023, 16'h0000, 16'hFFF0, 16'h0000, 128, "R4 sum -2046");
      run(10'd0, 10'd1023, 16'h0000, 16'hFFF0, 16'h0000, 128, "R4 sum at -bound");
      run(10'd0, 10'd1023, 16'h0000, 16'hFFF0, 16'h0000, 128, "R4 sum held at -bound");
      run(10'd1000, 10'd0, 16'h0000, 16'hFFF0, 16'h0000, 66, "R4 unwind from -bound");

      // R8 R10: reset clears sum and previous error
      do_reset();
      run(10'd520, 10'd500, 16'h0000, 16'h0100, 16'h0100, 40, "R8 R10 first sample after reset");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule